// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter that can be preset and chained. On each rising clock edge it clears, loads a parallel word, increments, or holds its state. Which of these happens depends on a fixed order of precedence among its control inputs. Two count enables are provided. Both must be high for the counter to increment, but only the trickle enable takes part in the terminal-count output. The terminal count is high when the state is all ones and the trickle enable is high.

Several counters can be chained into one wider synchronous counter. Each stage's terminal count drives the trickle enable of the stage above it, and all stages share the same clock. The parallel enable can then gate the whole chain without lengthening the carry path. A parameter selects the reset style. In one style an active-low clear acts at once, without waiting for the clock. In the other style the active-low clear is sampled on the clock edge like any other control input.

Top module: `casc_bin_counter`

## Requirements
- R1: With `ASYNC_RST`=1, a low `rst_n` forces `count` to zero at once, without waiting for a clock edge, and overrides every other input. `count` stays zero while `rst_n` is low.
- R2: With `ASYNC_RST`=0, a low `rst_n` leaves `count` unchanged until the next rising edge and clears it on that edge. The clear overrides load and count.
- R3: When reset is inactive and `load_n` is low (0), `count` takes the value of `din` on the next rising edge. This happens whatever the values of `en_par` and `en_trk`.
- R4: When reset is inactive, `load_n` is high and both `en_par` and `en_trk` are high, `count` increases by one on the next rising edge.
- R5: When reset is inactive, `load_n` is high and either `en_par` or `en_trk` is low, `count` keeps its value across the edge.
- R6: An increment from the all-ones state (15 at the default width of 4) gives zero.
- R7: `tc_out` is high exactly when `en_trk` is high and `count` is all ones. It follows a change of `en_trk` within the same cycle, without waiting for a clock edge.
- R8: `en_par` has no effect on `tc_out`.
- R9: Two 4-bit stages can be chained. In the chain the lower stage's `tc_out` drives the upper stage's `en_trk`, and both `en_par` inputs are high. The chain then counts 0 to 255 and back to 0. The upper stage's `tc_out` is high only at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge, except the asynchronous clear |
| rst_n | input | 1 | Active-low clear; acts asynchronously or synchronously depending on `ASYNC_RST` |
| load_n | input | 1 | Active-low parallel load enable |
| din | input | W | Parallel load data |
| en_par | input | 1 | Count enable that does not affect the terminal count |
| en_trk | input | 1 | Count enable that also qualifies the terminal count |
| count | output | W | Counter state |
| tc_out | output | 1 | Terminal count: high when `en_trk` is high and the state is all ones |

## Verification
Clear, load, increment and hold show up on `count` one rising edge after the inputs are applied. The driver sets inputs on the falling edge and queues the expected state. The monitor then compares it just after the following rising edge. Two results are due with no clock edge: the asynchronous clear and `tc_out`. The bench checks these about one nanosecond after the stimulus, in the middle of the cycle. It runs the two reset styles side by side to show that only the synchronous one waits for the edge. The two-stage chain is compared against a running index on every falling edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_INCR  = 2'd2,
    MODE_HOLD  = 2'd3
  } cbc_mode_e;
endpackage

// File: rtl/cbc_mode_sel.sv
module cbc_mode_sel
  import cbc_pkg::*;
(
  input  logic      sync_clr,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output cbc_mode_e mode
);
  // fixed precedence: clear, load, increment, hold
  always_comb begin
    if (sync_clr)             mode = MODE_CLEAR;
    else if (!load_n)         mode = MODE_LOAD;
    else if (en_par && en_trk) mode = MODE_INCR;
    else                      mode = MODE_HOLD;
  end
endmodule

// File: rtl/cbc_state_reg.sv
module cbc_state_reg
  import cbc_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cbc_mode_e    mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_INCR:  nxt = q + W'(1);
      default:    nxt = q;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/cbc_tc_decode.sv
module cbc_tc_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_trk,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONES = '1;
  assign tc = en_trk && (q == ALL_ONES);
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import cbc_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_par,
  input  logic         en_trk,
  output logic [W-1:0] count,
  output logic         tc_out
);
  cbc_mode_e mode;
  logic      sync_clr;

  // the asynchronous style clears at the flop, so the mode path never sees it
  assign sync_clr = ASYNC_RST ? 1'b0 : !rst_n;

  cbc_mode_sel u_mode (
    .sync_clr(sync_clr),
    .load_n  (load_n),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .mode    (mode)
  );

  cbc_state_reg #(.W(W), .ASYNC_RST(ASYNC_RST)) u_state (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode),
    .din  (din),
    .q    (count)
  );

  cbc_tc_decode #(.W(W)) u_tc (
    .q     (count),
    .en_trk(en_trk),
    .tc    (tc_out)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         en_par,
  input logic         en_trk,
  input logic [W-1:0] count,
  input logic         tc_out
);
  localparam logic [W-1:0] ALL_ONES = '1;

  AST_CLEAR_SEEN: assert property (@(posedge clk) disable iff (1'b0) !rst_n |=> count == '0); // R1
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) !load_n |=> count == $past(din)); // R3
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (load_n && en_par && en_trk) |=> count == W'($past(count) + W'(1))); // R4
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n) (load_n && !(en_par && en_trk)) |=> $stable(count)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (load_n && en_par && en_trk && count == ALL_ONES) |=> count == '0); // R6
  AST_TC_NEEDS_TRK: assert property (@(posedge clk) disable iff (!rst_n) tc_out |-> en_trk); // R7
  AST_TC_IGNORES_PAR: assert property (@(posedge clk) disable iff (!rst_n) (en_trk && count == ALL_ONES) |-> tc_out); // R8
endmodule

bind casc_bin_counter cbc_checker #(.W(W)) u_chk (.*);

// File: tb/casc_bin_counter_tb.sv
module casc_bin_counter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt_a, cnt_s;
  logic       tc_a, tc_s;

  casc_bin_counter #(.W(4), .ASYNC_RST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din), .en_par(en_par),
    .en_trk(en_trk), .count(cnt_a), .tc_out(tc_a));
  casc_bin_counter #(.W(4), .ASYNC_RST(1'b0)) u_dut_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din), .en_par(en_par),
    .en_trk(en_trk), .count(cnt_s), .tc_out(tc_s));

  // two-stage chain
  logic       c_rst_n = 1'b0, c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;
  casc_bin_counter #(.W(4)) u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0), .en_par(1'b1),
    .en_trk(c_en), .count(lo_q), .tc_out(lo_tc));
  casc_bin_counter #(.W(4)) u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0), .en_par(1'b1),
    .en_trk(lo_tc), .count(hi_q), .tc_out(hi_tc));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { logic [3:0] cnt; string req; } exp_t;
  exp_t sb[$];
  logic [3:0] mdl = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply at falling edge, queue the state due after the next rising edge
  task automatic step(input logic r, input logic ld, input logic [3:0] d,
                      input logic ep, input logic et, input string req);
    exp_t it;
    @(negedge clk);
    rst_n = r; load_n = ld; din = d; en_par = ep; en_trk = et;
    #1;
    if (r) chk(tc_a == (et && mdl == 4'hF), "R7", tc_a, et && mdl == 4'hF);
    if (!r)       mdl = '0;
    else if (!ld) mdl = d;
    else if (ep && et) mdl = mdl + 4'd1;
    it.cnt = mdl; it.req = req;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk(cnt_a == it.cnt, it.req, cnt_a, it.cnt);
        chk(cnt_s == it.cnt, it.req, cnt_s, it.cnt);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1;
    chk(cnt_a == 4'd0, "R1", cnt_a, 0);                  // async clear at time zero
    step(1'b0, 1'b0, 4'd9, 1'b1, 1'b1, "R1");            // reset overrides load and count
    step(1'b1, 1'b0, 4'd5, 1'b0, 1'b0, "R3");            // load with enables low
    step(1'b1, 1'b0, 4'd12, 1'b1, 1'b1, "R3");           // load beats count
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R4");            // 13
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R4");            // 14
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R5");            // hold, en_par low
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R5");            // hold, en_trk low
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R4");            // 15
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R8");            // hold at 15, tc checked with en_par low
    // combinational tc at state 15
    @(negedge clk);
    en_trk = 1'b0; #1;
    chk(tc_a == 1'b0, "R7", tc_a, 0);
    en_trk = 1'b1; #1;
    chk(tc_a == 1'b1, "R7", tc_a, 1);
    en_par = 1'b1; #1;
    chk(tc_a == 1'b1, "R8", tc_a, 1);
    en_par = 1'b0; #1;
    chk(tc_a == 1'b1, "R8", tc_a, 1);
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R6");            // 15 -> 0
    step(1'b1, 1'b0, 4'd7, 1'b0, 1'b0, "R3");            // load 7
    // clear asserted between edges
    @(negedge clk);
    load_n = 1'b0; din = 4'd9; en_par = 1'b1; en_trk = 1'b1;
    #5 rst_n = 1'b0;
    #1;
    chk(cnt_a == 4'd0, "R1", cnt_a, 0);
    chk(cnt_s == 4'd7, "R2", cnt_s, 7);
    @(posedge clk); #2;
    chk(cnt_s == 4'd0, "R2", cnt_s, 0);
    chk(cnt_a == 4'd0, "R1", cnt_a, 0);
    mdl = '0;
    step(1'b0, 1'b0, 4'd3, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R4");
    @(negedge clk); @(negedge clk);

    // chain
    @(negedge clk);
    c_rst_n = 1'b1; c_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      chk({hi_q, lo_q} == 8'(i), "R9", {hi_q, lo_q}, i);
      if (i == 255 || i == 254) chk(hi_tc == (i == 255), "R9", hi_tc, i == 255);
      @(negedge clk);
    end
    chk({hi_q, lo_q} == 8'd0, "R9", {hi_q, lo_q}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule